// File: doc/BRIEF.md
# Serial Transmitter with Address Marking and Break Generation

This block serializes bytes onto an asynchronous serial line. A byte written into a single-entry holding buffer is turned into a frame: a low start bit, seven or eight data bits in either bit order, an optional marker bit for address-bit networks, an optional parity bit of either sense, and one or two high stop bits. Every line transition is paced by an external one-cycle bit-rate enable. The block does not generate the baud rate itself.

Two one-shot controls change the next frame. The address control marks it as an address. In address-bit mode this sets the marker bit. In idle-line mode the frame is preceded by a long mark period. The break control turns the next frame into a break, which holds the line low for a long time. In auto-baud mode the break is followed by a programmable high delimiter and then the written byte, which is normally 0x55 so that the receiver sees a synch character. A buffer-empty flag lets the next byte be loaded while the current frame is still going out, so frames can run back to back.

Top module: `uart_tx_core`

## Requirements
- R1: With the line idle, `txd` is 1. A frame is a 0 start bit, then the data bits (`seven_bit`=1 sends the low 7 bits, otherwise 8), least significant first when `msb_first`=0 and most significant of the sent bits first when it is 1, then one stop bit of value 1 (two when `two_stop`=1). Each bit lasts one `bit_tick` period.
- R2: With `par_en`=1, a parity bit follows the data bits (and the marker bit, when present) and comes before the stop bits. With `par_even`=1 it makes the total count of ones over the data, marker and parity bits even. With `par_even`=0 it makes that count odd. With `par_en`=0 no parity bit is sent.
- R3: In address-bit mode (`mode`=2), a marker bit is sent right after the data bits. It is 1 when the address control is pending at frame start, otherwise 0, and it counts in the parity.
- R4: In idle-line mode (`mode`=1), a frame sent with the address control pending is preceded by 11 bit times of 1. A data frame gets no such prefix.
- R5: In the modes that are not auto-baud (`mode`=0, 1 or 2), a frame sent with the break control pending is 13 bit times of 0 followed by one bit time of 1. The written byte is not sent.
- R6: In auto-baud mode (`mode`=3), a break frame is 13 bit times of 0, then `delim`+1 bit times of 1, then the written byte as a complete frame per R1 and R2.
- R7: A one-cycle pulse on `set_addr` or `set_brk` makes the matching pending output 1. Both pending outputs return to 0 when the next frame starts. In `mode`=0 and `mode`=3 a pending address control does not change the frame.
- R8: A write is accepted only while `buf_empty` is 1, and `buf_empty` is 0 in the cycle after the write. A write while `buf_empty` is 0 is dropped. The buffer empties when its frame starts, and a byte already waiting when the last bit of a frame ends starts in the next bit period with no idle bit in between.
- R9: `busy` is 1 from the start of a frame (including any prefix, break or delimiter) to the end of its last bit, and 0 otherwise. `txd` changes only on clock edges where `bit_tick` is 1.
- R10: After reset, `txd`=1, `buf_empty`=1, `busy`=0, `addr_pend`=0 and `brk_pend`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Byte to transmit |
| set_addr | input | 1 | Pulse: mark the next frame as an address |
| set_brk | input | 1 | Pulse: make the next frame a break |
| par_en | input | 1 | Parity enable |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| msb_first | input | 1 | Bit order select |
| seven_bit | input | 1 | 1 = send DATA_W-1 data bits |
| two_stop | input | 1 | 1 = two stop bits |
| mode | input | 2 | 0 plain, 1 idle-line, 2 address-bit, 3 auto-baud |
| delim | input | 2 | Delimiter length after break, code+1 bit times |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer can take a byte |
| busy | output | 1 | Frame in progress |
| addr_pend | output | 1 | Address control pending |
| brk_pend | output | 1 | Break control pending |

## Verification
The assertions assume that the format inputs (`mode`, `delim`, parity, order, length and stop selects) do not change while `busy` is 1, because the frame is laid out once at launch. They also assume that `bit_tick` is a single-cycle pulse spaced at least two cycles apart. The stimulus changes the format only while the line is idle and the buffer is empty. It drives `bit_tick` on a fixed four-cycle pattern and samples the line once per bit, in the middle of the bit period.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
package utx_pkg;
   typedef enum logic [1:0] {
      MODE_PLAIN    = 2'd0,
      MODE_IDLE     = 2'd1,
      MODE_ADDRBIT  = 2'd2,
      MODE_AUTOBAUD = 2'd3
   } utx_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_BRK,
      ST_DELIM,
      ST_FRAME
   } utx_state_e;
endpackage

// File: rtl/utx_hold.sv
`timescale 1ns/1ps
module utx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              set_addr,
   input  logic              set_brk,
   input  logic              launch,
   output logic              buf_empty,
   output logic [DATA_W-1:0] data_q,
   output logic              addr_pend,
   output logic              brk_pend
);
   logic accept;
   assign accept = wr_en && buf_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_empty <= 1'b1;
         data_q    <= '0;
         addr_pend <= 1'b0;
         brk_pend  <= 1'b0;
      end else begin
         if (accept) begin
            buf_empty <= 1'b0;
            data_q    <= wr_data;
         end else if (launch) begin
            buf_empty <= 1'b1;
         end
         // a set pulse in the launch cycle belongs to the following frame
         if (set_addr)    addr_pend <= 1'b1;
         else if (launch) addr_pend <= 1'b0;
         if (set_brk)     brk_pend  <= 1'b1;
         else if (launch) brk_pend  <= 1'b0;
      end
   end

   assert_wr_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && buf_empty |=> !buf_empty);
   assert_full_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_empty && !launch |=> $stable(data_q) && !buf_empty);
   assert_brk_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      launch && !set_brk |=> !brk_pend);
   assert_addr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      launch && !set_addr |=> !addr_pend);
endmodule

// File: rtl/utx_fmt.sv
`timescale 1ns/1ps
module utx_fmt
   import utx_pkg::*;
#(
   parameter  int DATA_W      = 8,
   parameter  bit PAR_SUPPORT = 1'b1,
   localparam int FR_W        = DATA_W + 5,
   localparam int LEN_W       = $clog2(FR_W + 1)
) (
   input  logic [DATA_W-1:0] data,
   input  logic              addr,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              msb_first,
   input  logic              seven_bit,
   input  logic              two_stop,
   input  utx_mode_e         mode,
   output logic [FR_W-1:0]   frame,
   output logic [LEN_W-1:0]  len
);
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] ordered;
   logic              mark_on;
   logic              par_used;
   logic              par_bit;
   int                dlen;

   assign mark_on = (mode == MODE_ADDRBIT);
   assign dlen    = seven_bit ? DATA_W - 1 : DATA_W;

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         int idx;
         idx        = (i < dlen) ? dlen - 1 - i : 0;
         mask[i]    = (i < dlen);
         ordered[i] = msb_first ? ((i < dlen) && data[idx]) : data[i];
      end
   end

   generate
      if (PAR_SUPPORT) begin : g_par
         logic ones_odd;
         assign ones_odd = (^(data & mask)) ^ (mark_on & addr);
         assign par_bit  = par_even ? ones_odd : ~ones_odd;
         assign par_used = par_en;
      end else begin : g_nopar
         assign par_bit  = 1'b0;
         assign par_used = 1'b0;
      end
   endgenerate

   always_comb begin
      int pos;
      frame    = '1;
      frame[0] = 1'b0;
      pos      = 1;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < dlen) begin
            frame[pos] = ordered[i];
            pos++;
         end
      end
      if (mark_on) begin
         frame[pos] = addr;
         pos++;
      end
      if (par_used) begin
         frame[pos] = par_bit;
         pos++;
      end
      pos = pos + (two_stop ? 2 : 1);
      len = LEN_W'(pos);
   end
endmodule

// File: rtl/utx_seq.sv
`timescale 1ns/1ps
module utx_seq
   import utx_pkg::*;
#(
   parameter int FR_W     = 13,
   parameter int LEN_W    = 4,
   parameter int CNT_W    = 4,
   parameter int BRK_BITS = 13,
   parameter int GAP_BITS = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             full,
   input  logic             addr_pend,
   input  logic             brk_pend,
   input  utx_mode_e        mode,
   input  logic [1:0]       delim,
   input  logic [FR_W-1:0]  frame,
   input  logic [LEN_W-1:0] flen_in,
   output logic             launch,
   output logic             txd,
   output logic             busy
);
   utx_state_e       st, st_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic [FR_W-1:0]  sr, sr_n;
   logic [LEN_W-1:0] flen, flen_n;
   logic             tail, tail_n;
   logic             finish;

   always_comb begin
      st_n   = st;
      cnt_n  = cnt;
      sr_n   = sr;
      flen_n = flen;
      tail_n = tail;
      launch = 1'b0;
      finish = 1'b0;
      if (bit_tick) begin
         unique case (st)
            ST_IDLE: finish = 1'b1;
            ST_GAP: begin
               if (cnt == '0) begin
                  st_n  = ST_FRAME;
                  cnt_n = CNT_W'(flen - 1'b1);
               end else cnt_n = cnt - 1'b1;
            end
            ST_BRK: begin
               if (cnt == '0) begin
                  st_n  = ST_DELIM;
                  cnt_n = tail ? CNT_W'(delim) : '0;
               end else cnt_n = cnt - 1'b1;
            end
            ST_DELIM: begin
               if (cnt != '0) cnt_n = cnt - 1'b1;
               else if (tail) begin
                  st_n  = ST_FRAME;
                  cnt_n = CNT_W'(flen - 1'b1);
               end else finish = 1'b1;
            end
            ST_FRAME: begin
               sr_n = {1'b1, sr[FR_W-1:1]};
               if (cnt == '0) finish = 1'b1;
               else cnt_n = cnt - 1'b1;
            end
            default: st_n = ST_IDLE;
         endcase
         if (finish) begin
            st_n = ST_IDLE;
            if (full) begin
               launch = 1'b1;
               sr_n   = frame;
               flen_n = flen_in;
               tail_n = 1'b0;
               if (brk_pend) begin
                  st_n   = ST_BRK;
                  cnt_n  = CNT_W'(BRK_BITS - 1);
                  tail_n = (mode == MODE_AUTOBAUD);
               end else if (addr_pend && mode == MODE_IDLE) begin
                  st_n  = ST_GAP;
                  cnt_n = CNT_W'(GAP_BITS - 1);
               end else begin
                  st_n  = ST_FRAME;
                  cnt_n = CNT_W'(flen_in - 1'b1);
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         sr   <= '1;
         flen <= '0;
         tail <= 1'b0;
      end else begin
         st   <= st_n;
         cnt  <= cnt_n;
         sr   <= sr_n;
         flen <= flen_n;
         tail <= tail_n;
      end
   end

   assign txd  = (st == ST_BRK) ? 1'b0 : ((st == ST_FRAME) ? sr[0] : 1'b1);
   assign busy = (st != ST_IDLE);

   assert_tick_paced_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(txd));
   assert_brk_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_BRK && bit_tick && cnt == '0 |=> txd && busy);
   assert_cnt_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_FRAME |-> cnt < CNT_W'(flen));
   assert_launch_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      launch && !brk_pend && !(addr_pend && mode == MODE_IDLE) |=> !txd && busy);
endmodule

// File: rtl/uart_tx_core.sv
`timescale 1ns/1ps
module uart_tx_core
   import utx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int BRK_BITS    = 13,
   parameter int GAP_BITS    = 11,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              set_addr,
   input  logic              set_brk,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              msb_first,
   input  logic              seven_bit,
   input  logic              two_stop,
   input  logic [1:0]        mode,
   input  logic [1:0]        delim,
   output logic              txd,
   output logic              buf_empty,
   output logic              busy,
   output logic              addr_pend,
   output logic              brk_pend
);
   localparam int FR_W   = DATA_W + 5;
   localparam int LEN_W  = $clog2(FR_W + 1);
   localparam int MAX_A  = (BRK_BITS > GAP_BITS) ? BRK_BITS : GAP_BITS;
   localparam int MAX_PH = (MAX_A > FR_W) ? MAX_A : FR_W;
   localparam int CNT_W  = $clog2(MAX_PH + 1);

   generate
      if (DATA_W < 6 || DATA_W > 9) begin : g_bad_width
         $error("uart_tx_core: DATA_W must lie in 6..9");
      end
      if (BRK_BITS < 2 || GAP_BITS < 1) begin : g_bad_len
         $error("uart_tx_core: BRK_BITS >= 2 and GAP_BITS >= 1 required");
      end
   endgenerate

   utx_mode_e         mode_e;
   logic [DATA_W-1:0] data_q;
   logic [FR_W-1:0]   frame;
   logic [LEN_W-1:0]  flen;
   logic              launch;

   assign mode_e = utx_mode_e'(mode);

   utx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .set_addr(set_addr), .set_brk(set_brk), .launch(launch),
      .buf_empty(buf_empty), .data_q(data_q),
      .addr_pend(addr_pend), .brk_pend(brk_pend)
   );

   utx_fmt #(.DATA_W(DATA_W), .PAR_SUPPORT(PAR_SUPPORT)) u_fmt (
      .data(data_q), .addr(addr_pend), .par_en(par_en), .par_even(par_even),
      .msb_first(msb_first), .seven_bit(seven_bit), .two_stop(two_stop),
      .mode(mode_e), .frame(frame), .len(flen)
   );

   utx_seq #(
      .FR_W(FR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
      .BRK_BITS(BRK_BITS), .GAP_BITS(GAP_BITS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .full(!buf_empty),
      .addr_pend(addr_pend), .brk_pend(brk_pend), .mode(mode_e), .delim(delim),
      .frame(frame), .flen_in(flen), .launch(launch), .txd(txd), .busy(busy)
   );

   assert_idle_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && buf_empty |=> !busy);
endmodule

// File: tb/tb_uart_tx_core.sv
`timescale 1ns/1ps
module tb_uart_tx_core;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic set_addr = 1'b0, set_brk = 1'b0;
   logic pe = 1'b0, pev = 1'b0, msb = 1'b0, seven = 1'b0, ts = 1'b0;
   logic [1:0] md = 2'd0, dl = 2'd0;
   logic txd, buf_empty, busy, addr_pend, brk_pend;

   int checks = 0;
   int fails  = 0;
   int ph     = 0;
   bit rec[$];
   bit expq[$];

   uart_tx_core dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
      .wr_data(wr_data), .set_addr(set_addr), .set_brk(set_brk),
      .par_en(pe), .par_even(pev), .msb_first(msb), .seven_bit(seven),
      .two_stop(ts), .mode(md), .delim(dl), .txd(txd), .buf_empty(buf_empty),
      .busy(busy), .addr_pend(addr_pend), .brk_pend(brk_pend)
   );

   always #2 clk = ~clk;

   // bit-rate pacing and mid-bit line sampling
   initial begin
      forever begin
         @(negedge clk);
         ph = (ph + 1) % 4;
         bit_tick = (ph == 0);
         if (ph == 2 && busy) rec.push_back(txd);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(string req, int got, int expv);
      checks++;
      if (got != expv) begin
         fails++;
         $display("FAIL %s: got %0d exp %0d", req, got, expv);
      end
   endtask

   task automatic push_n(bit v, int n);
      for (int i = 0; i < n; i++) expq.push_back(v);
   endtask

   task automatic push_frame(logic [7:0] d, bit a);
      int n = seven ? 7 : 8;
      int ones = 0;
      expq.push_back(1'b0);
      for (int i = 0; i < n; i++) begin
         expq.push_back(msb ? d[n-1-i] : d[i]);
         ones += d[i];
      end
      if (md == 2'd2) begin
         expq.push_back(a);
         ones += a;
      end
      if (pe) expq.push_back(pev ? bit'(ones % 2) : bit'(1 - ones % 2));
      push_n(1'b1, ts ? 2 : 1);
   endtask

   task automatic cmp_stream(string req);
      bit bad = (rec.size() != expq.size());
      longint g = 0, e = 0;
      if (!bad) for (int i = 0; i < rec.size(); i++) if (rec[i] != expq[i]) bad = 1;
      for (int i = 0; i < rec.size() && i < 64; i++) g[i] = rec[i];
      for (int i = 0; i < expq.size() && i < 64; i++) e[i] = expq[i];
      checks++;
      if (bad) begin
         fails++;
         $display("FAIL %s: got %0d bits 0x%0h exp %0d bits 0x%0h",
                  req, rec.size(), g, expq.size(), e);
      end
   endtask

   task automatic pulse_addr();
      set_addr = 1'b1; step(); set_addr = 1'b0;
   endtask

   task automatic pulse_brk();
      set_brk = 1'b1; step(); set_brk = 1'b0;
   endtask

   task automatic wait_done(string req);
      int k = 0;
      while (!busy && k < 40) begin step(); k++; end
      k = 0;
      while (busy && k < 400) begin step(); k++; end
      if (busy || k == 0) begin
         fails++;
         $display("FAIL %s: got busy timeout exp frame", req);
      end
      step();
   endtask

   task automatic run_case(logic [7:0] d, bit a, bit b, string req);
      if (a) pulse_addr();
      if (b) pulse_brk();
      expq.delete();
      if (b) begin
         push_n(1'b0, 13);
         if (md == 2'd3) begin
            push_n(1'b1, dl + 1);
            push_frame(d, a);
         end else push_n(1'b1, 1);
      end else begin
         if (a && md == 2'd1) push_n(1'b1, 11);
         push_frame(d, a);
      end
      rec.delete();
      wr_data = d; wr_en = 1'b1; step(); wr_en = 1'b0;
      wait_done(req);
      cmp_stream(req);
   endtask

   initial begin
      repeat (3) step();
      // R10: reset values
      chk("R10 txd", txd, 1);
      chk("R10 buf_empty", buf_empty, 1);
      chk("R10 busy", busy, 0);
      chk("R10 pend", {addr_pend, brk_pend}, 0);
      rst_n = 1'b1;
      repeat (3) step();

      // R1 R2 R3 R4 R7: sweep every format and mode with and without address
      for (int c = 0; c < 128; c++) begin
         seven = c[0]; msb = c[1]; pe = c[2]; pev = c[3]; ts = c[4]; md = c[6:5];
         step();
         run_case(8'((c * 37 + 5) & 8'hff), c[1] ^ c[4], 1'b0, "R1 R2 R3 R4 R7 sweep");
      end

      // R5: breaks outside auto-baud drop the byte
      seven = 0; msb = 0; pe = 0; pev = 0; ts = 0;
      md = 2'd0; step(); run_case(8'h00, 1'b0, 1'b1, "R5 plain break");
      md = 2'd2; step(); run_case(8'h00, 1'b0, 1'b1, "R5 addrbit break");

      // R6: auto-baud break, delimiter, synch for every delimiter code
      md = 2'd3;
      for (int k = 0; k < 4; k++) begin
         dl = 2'(k); pe = k[0]; pev = k[1];
         step();
         run_case(8'h55, 1'b0, 1'b1, "R6 break synch");
      end
      pe = 0; pev = 0; dl = 0;

      // R7: pending flags set by pulses, cleared at launch
      md = 2'd0; step();
      pulse_brk(); pulse_addr();
      chk("R7 brk_pend set", brk_pend, 1);
      chk("R7 addr_pend set", addr_pend, 1);
      rec.delete(); expq.delete();
      push_n(1'b0, 13); push_n(1'b1, 1);
      wr_data = 8'h00; wr_en = 1'b1; step(); wr_en = 1'b0;
      while (!busy) step();
      step();
      chk("R7 brk_pend cleared", brk_pend, 0);
      chk("R7 addr_pend cleared", addr_pend, 0);
      chk("R9 busy in break", busy, 1);
      wait_done("R7");
      cmp_stream("R7 R5 break stream");
      chk("R9 busy after", busy, 0);
      chk("R9 line idle", txd, 1);

      // R8: write while full dropped, back-to-back without idle bit
      while (ph != 1) step();
      rec.delete(); expq.delete();
      wr_data = 8'hA5; wr_en = 1'b1; step();
      chk("R8 buffer taken", buf_empty, 0);
      wr_data = 8'h3C; step(); wr_en = 1'b0;
      chk("R8 full stays full", buf_empty, 0);
      while (!busy) step();
      chk("R8 freed at start", buf_empty, 1);
      wr_data = 8'h0F; wr_en = 1'b1; step(); wr_en = 1'b0;
      push_frame(8'hA5, 1'b0);
      push_frame(8'h0F, 1'b0);
      wait_done("R8");
      cmp_stream("R8 back-to-back, dropped write");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule